// File: doc/BRIEF.md
# Locality-gated command/response register interface

A device-side register block for a secure-module style host interface. The host sees a row of 4 KiB windows, one per locality. It claims a locality through the access register of that window. It then arms the block through the status register and streams a command into a byte-wide data port. When the command is complete it starts execution and finally drains the response through the same port. Flow control is visible in the status word. A burst count, an expect flag and a data-available flag follow the progress of the command against the length carried in its own header, and the progress of the response as it is read.

A command processor sits behind the block. It reads the buffered command through a random-access byte port and sees `exec_o` while it owns the transaction. It appends response bytes one per cycle and pulses `done_i` when it has finished. The command processor and interrupt generation are not part of this block.

Top module: `lcr_regif`

## Requirements
- R1: The address splits into a window number (bits above 11) and a 12-bit offset. Windows 0..N_LOC-1 decode the access register at 0x000, status at 0x018, the data port at 0x024, the identity word at 0xF00 (device ID in bits 31:16, vendor ID in bits 15:0) and the revision at 0xF04 (bits 7:0). Any other offset in a valid window reads 0. Any address in a window at or above N_LOC reads 0xFFFFFFFF.
- R2: Access register reads return bit 7 = 1 always, and bit 5 = 1 only in the window that owns the block. A write with bit 1 set claims ownership for its window only when no window owns the block. A write with bit 5 set, from the owning window, releases ownership. A release takes priority within one write.
- R3: Status and data-port reads from any window other than the owner return 0xFFFFFFFF, and writes to them from such a window change nothing.
- R4: Status word layout: bit 7 valid (always 1), bit 6 command-ready, bit 4 data-available, bit 3 expect, bits 23:8 burst count, all other bits 0. After reset the block is idle: status reads 0x00000080.
- R5: A status write with bit 6 set, in any state except execution, enters the ready state. The command and response buffers empty, `overflow_o` clears, command-ready and expect read 1, and the burst count reads CMD_DEPTH.
- R6: Each accepted data-port write appends a byte to the command. The burst count then reads the free space (CMD_DEPTH minus bytes held). Expect stays 1 until at least 6 bytes are held and the count reaches the big-endian length in command bytes 2..5, or until the buffer is full. It then reads 0.
- R7: A data-port write received while a command is being received and expect is 0 is discarded, and it sets `overflow_o`, which holds until the next ready entry.
- R8: A status write with bit 5 set starts execution only when a received command is complete; otherwise it is ignored. During execution `exec_o` is 1, the burst count is 0, and `cmd_byte_o` shows command byte `cmd_idx_i`.
- R9: During execution each `rsp_wr_i` cycle appends `rsp_byte_i` to the response, and bytes beyond RSP_DEPTH are dropped. `done_i` moves the block to the response state, where the burst count is the number of unread bytes and data-available is 1 while any remain.
- R10: In the response state each data-port read returns the next response byte in bits 7:0, upper bits 0, and advances. A read with nothing left, or outside the response state, returns 0x000000FF. Data-available drops after the last byte has been read.
- R11: A status write with bit 1 set, in the response state, rewinds the response so that the next read returns its first byte again.
- R12: During execution, status writes with bit 6 set and data-port writes are ignored; only `done_i` ends execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address: window number above bit 11, offset below |
| bus_wdata_i | input | 32 | Write data; the data port uses bits 7:0 |
| bus_rdata_o | output | 32 | Read data, combinational from the current address |
| cmd_idx_i | input | log2(CMD_DEPTH) | Command byte index for the processor |
| cmd_byte_o | output | 8 | Command byte at `cmd_idx_i` |
| exec_o | output | 1 | Command executing |
| rsp_wr_i | input | 1 | Append `rsp_byte_i` to the response |
| rsp_byte_i | input | 8 | Response byte |
| done_i | input | 1 | Execution finished |
| overflow_o | output | 1 | Sticky: command byte arrived after expect dropped |

## Verification
The bench builds the block with five windows, a 16-byte command buffer and an 8-byte response buffer. The small command buffer puts the buffer-full end of a command, where the header length exceeds the space, within a handful of writes. The small response buffer lets a ten-byte response from the stub overrun its limit, so the dropped tail and the exact unread counts are exercised. The default identity and revision values are kept, so the identity decode is checked against the parameter defaults the block ships with.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READY, ST_RECV, ST_EXEC, ST_RESP
  } lcr_state_e;

  localparam logic [11:0] OFF_ACC = 12'h000;
  localparam logic [11:0] OFF_STS = 12'h018;
  localparam logic [11:0] OFF_DAT = 12'h024;
  localparam logic [11:0] OFF_ID  = 12'hF00;
  localparam logic [11:0] OFF_REV = 12'hF04;

  localparam int STS_READY = 6;
  localparam int STS_GO    = 5;
  localparam int STS_RETRY = 1;
  localparam int ACC_OWN   = 5;
  localparam int ACC_CLAIM = 1;

  localparam int HDR_BYTES = 6;
endpackage

// File: rtl/lcr_loc_arb.sv
module lcr_loc_arb #(
  parameter int N_LOC = 5,
  localparam int WIN_W = (N_LOC > 1) ? $clog2(N_LOC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIN_W-1:0] wr_win_i,
  input  logic             claim_i,
  input  logic             release_i,
  output logic             own_vld_o,
  output logic [WIN_W-1:0] own_win_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vld_o <= 1'b0;
      own_win_o <= '0;
    end else if (wr_i) begin
      if (release_i && own_vld_o && own_win_o == wr_win_i) begin
        own_vld_o <= 1'b0;
      end else if (claim_i && !own_vld_o) begin
        own_vld_o <= 1'b1;
        own_win_o <= wr_win_i;
      end
    end
  end
endmodule

// File: rtl/lcr_cmd_buf.sv
module lcr_cmd_buf import lcr_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [7:0]    din_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_byte_o,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  logic [7:0]  mem_q [DEPTH];
  logic [31:0] len_q;
  logic        room;

  assign room = cnt_o < CW'(DEPTH);

  always_ff @(posedge clk_i) begin
    if (push_i && room) mem_q[cnt_o[IW-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      len_q <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
      len_q <= '0;
    end else if (push_i && room) begin
      cnt_o <= cnt_o + 1'b1;
      // header bytes 2..5 carry the total length, most significant first
      if (cnt_o >= CW'(2) && cnt_o < CW'(HDR_BYTES)) len_q <= {len_q[23:0], din_i};
    end
  end

  assign done_o    = !room || (cnt_o >= CW'(HDR_BYTES) && 32'(cnt_o) >= len_q);
  assign rd_byte_o = mem_q[rd_idx_i];
endmodule

// File: rtl/lcr_rsp_buf.sv
module lcr_rsp_buf #(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [7:0]    din_i,
  input  logic          pop_i,
  input  logic          rewind_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] rd_o,
  output logic [7:0]    dout_o
);
  logic [7:0] mem_q [DEPTH];
  logic       room;

  assign room = cnt_o < CW'(DEPTH);

  always_ff @(posedge clk_i) begin
    if (load_i && room) mem_q[cnt_o[IW-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      rd_o  <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
      rd_o  <= '0;
    end else begin
      if (load_i && room) cnt_o <= cnt_o + 1'b1;
      if (rewind_i)                  rd_o <= '0;
      else if (pop_i && rd_o < cnt_o) rd_o <= rd_o + 1'b1;
    end
  end

  assign dout_o = mem_q[rd_o[IW-1:0]];
endmodule

// File: rtl/lcr_regif.sv
module lcr_regif import lcr_pkg::*; #(
  parameter int          N_LOC     = 5,
  parameter int          CMD_DEPTH = 64,
  parameter int          RSP_DEPTH = 64,
  parameter logic [15:0] VENDOR_ID = 16'h1D5A,
  parameter logic [15:0] DEVICE_ID = 16'h00C3,
  parameter logic [7:0]  REV_ID    = 8'h07,
  localparam int WIN_W  = (N_LOC > 1) ? $clog2(N_LOC) : 1,
  localparam int ADDR_W = WIN_W + 12,
  localparam int CIW    = $clog2(CMD_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [CIW-1:0]    cmd_idx_i,
  output logic [7:0]        cmd_byte_o,
  output logic              exec_o,
  input  logic              rsp_wr_i,
  input  logic [7:0]        rsp_byte_i,
  input  logic              done_i,
  output logic              overflow_o
);
  localparam int CCW = $clog2(CMD_DEPTH + 1);
  localparam int RCW = $clog2(RSP_DEPTH + 1);

  lcr_state_e       state_q, state_d;
  logic [WIN_W-1:0] win, own_win;
  logic [11:0]      off;
  logic             in_rng, own_vld, own;
  logic             acc_wr, sts_wr, dat_wr, dat_rd;
  logic             rdy_cmd, go_cmd, retry_cmd, push, ovf_set, ovf_q;
  logic [CCW-1:0]   cmd_cnt;
  logic             cmd_done;
  logic [RCW-1:0]   rsp_cnt, rsp_rd;
  logic [7:0]       rsp_dout;
  logic             avail, expect_f;
  logic [15:0]      burst;
  logic [31:0]      sts_word;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata_i[31:8];

  assign win    = bus_addr_i[ADDR_W-1:12];
  assign off    = bus_addr_i[11:0];
  assign in_rng = int'(win) < N_LOC;
  assign own    = own_vld && own_win == win;

  assign acc_wr = bus_en_i &&  bus_we_i && in_rng && off == OFF_ACC;
  assign sts_wr = bus_en_i &&  bus_we_i && own && off == OFF_STS;
  assign dat_wr = bus_en_i &&  bus_we_i && own && off == OFF_DAT;
  assign dat_rd = bus_en_i && !bus_we_i && own && off == OFF_DAT;

  // one command per status write: ready over go over retry
  assign rdy_cmd   = sts_wr && bus_wdata_i[STS_READY] && state_q != ST_EXEC;
  assign go_cmd    = sts_wr && !rdy_cmd && bus_wdata_i[STS_GO] && state_q == ST_RECV && cmd_done;
  assign retry_cmd = sts_wr && !rdy_cmd && !go_cmd && bus_wdata_i[STS_RETRY] && state_q == ST_RESP;
  assign push      = dat_wr && (state_q == ST_READY || (state_q == ST_RECV && !cmd_done));
  assign ovf_set   = dat_wr && state_q == ST_RECV && cmd_done;

  lcr_loc_arb #(.N_LOC(N_LOC)) u_arb (
    .clk_i, .rst_ni,
    .wr_i      (acc_wr),
    .wr_win_i  (win),
    .claim_i   (bus_wdata_i[ACC_CLAIM]),
    .release_i (bus_wdata_i[ACC_OWN]),
    .own_vld_o (own_vld),
    .own_win_o (own_win)
  );

  lcr_cmd_buf #(.DEPTH(CMD_DEPTH)) u_cmd (
    .clk_i, .rst_ni,
    .clr_i     (rdy_cmd),
    .push_i    (push),
    .din_i     (bus_wdata_i[7:0]),
    .rd_idx_i  (cmd_idx_i),
    .rd_byte_o (cmd_byte_o),
    .cnt_o     (cmd_cnt),
    .done_o    (cmd_done)
  );

  lcr_rsp_buf #(.DEPTH(RSP_DEPTH)) u_rsp (
    .clk_i, .rst_ni,
    .clr_i    (rdy_cmd),
    .load_i   (rsp_wr_i && state_q == ST_EXEC),
    .din_i    (rsp_byte_i),
    .pop_i    (dat_rd && state_q == ST_RESP),
    .rewind_i (retry_cmd),
    .cnt_o    (rsp_cnt),
    .rd_o     (rsp_rd),
    .dout_o   (rsp_dout)
  );

  always_comb begin
    state_d = state_q;
    if (rdy_cmd)                            state_d = ST_READY;
    else if (push && state_q == ST_READY)   state_d = ST_RECV;
    else if (go_cmd)                        state_d = ST_EXEC;
    else if (state_q == ST_EXEC && done_i)  state_d = ST_RESP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (rdy_cmd)      ovf_q <= 1'b0;
      else if (ovf_set) ovf_q <= 1'b1;
    end
  end

  assign avail    = state_q == ST_RESP && rsp_rd < rsp_cnt;
  assign expect_f = (state_q == ST_READY || state_q == ST_RECV) && !cmd_done;

  always_comb begin
    unique case (state_q)
      ST_READY, ST_RECV: burst = 16'(CMD_DEPTH) - 16'(cmd_cnt);
      ST_RESP:           burst = 16'(rsp_cnt) - 16'(rsp_rd);
      default:           burst = '0;
    endcase
  end

  assign sts_word = {8'h00, burst, 1'b1, state_q == ST_READY, 1'b0, avail, expect_f, 3'b000};

  always_comb begin
    bus_rdata_o = '0;
    if (!in_rng) begin
      bus_rdata_o = '1;
    end else begin
      unique case (off)
        OFF_ACC: bus_rdata_o = {24'h0, 1'b1, 1'b0, own, 5'b0};
        OFF_STS: bus_rdata_o = own ? sts_word : '1;
        OFF_DAT: bus_rdata_o = !own ? '1 : (avail ? {24'h0, rsp_dout} : 32'h0000_00FF);
        OFF_ID:  bus_rdata_o = {DEVICE_ID, VENDOR_ID};
        OFF_REV: bus_rdata_o = {24'h0, REV_ID};
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign exec_o     = state_q == ST_EXEC;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/lcr_regif_chk.sv
module lcr_regif_chk import lcr_pkg::*; #(
  parameter int CMD_DEPTH = 64,
  parameter int CCW = 7,
  parameter int RCW = 7,
  parameter int WIN_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input lcr_state_e       state_i,
  input logic [CCW-1:0]   cmd_cnt_i,
  input logic             cmd_done_i,
  input logic [RCW-1:0]   rsp_cnt_i,
  input logic [RCW-1:0]   rsp_rd_i,
  input logic             ovf_i,
  input logic             dat_wr_i,
  input logic             acc_wr_i,
  input logic             own_vld_i,
  input logic [WIN_W-1:0] own_win_i,
  input logic             done_i
);
  // R2
  owner_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(acc_wr_i) |-> ($stable(own_vld_i) && $stable(own_win_i)));

  // R6
  cmd_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_cnt_i <= CCW'(CMD_DEPTH));

  // R7
  overflow_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> $past(dat_wr_i && cmd_done_i));

  // R8
  go_complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EXEC && $past(state_i) != ST_EXEC) |-> $past(cmd_done_i));

  // R10
  rsp_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_rd_i <= rsp_cnt_i);

  // R12
  exec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == ST_EXEC && !$past(done_i)) |-> state_i == ST_EXEC);
endmodule

bind lcr_regif lcr_regif_chk #(
  .CMD_DEPTH(CMD_DEPTH), .CCW(CCW), .RCW(RCW), .WIN_W(WIN_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (state_q),
  .cmd_cnt_i  (cmd_cnt),
  .cmd_done_i (cmd_done),
  .rsp_cnt_i  (rsp_cnt),
  .rsp_rd_i   (rsp_rd),
  .ovf_i      (ovf_q),
  .dat_wr_i   (dat_wr),
  .acc_wr_i   (acc_wr),
  .own_vld_i  (own_vld),
  .own_win_i  (own_win),
  .done_i     (done_i)
);

// File: tb/sim_lcr_regif.sv
module sim_lcr_regif;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 5;
  localparam int CD = 16;
  localparam int RD = 8;
  localparam logic [31:0] ID_WORD = 32'h00C3_1D5A;
  localparam logic [31:0] REV_WORD = 32'h0000_0007;
  localparam int S_IDLE = 0, S_READY = 1, S_RECV = 2, S_EXEC = 3, S_RESP = 4;
  localparam int ACC = 'h000, STS = 'h018, DAT = 'h024, IDR = 'hF00, REV = 'hF04;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_en_i = 1'b0, bus_we_i = 1'b0;
  logic [14:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [3:0]  cmd_idx_i = '0;
  logic [7:0]  cmd_byte_o;
  logic        exec_o, overflow_o;
  logic        rsp_wr_i = 1'b0, done_i = 1'b0;
  logic [7:0]  rsp_byte_i = '0;

  int checks = 0, failures = 0;
  bit run_cmp = 1'b0;

  // reference model
  int         m_own = -1;
  int         m_state = S_IDLE;
  logic [7:0] cq[$];
  logic [7:0] rq[$];
  int         m_rd = 0;
  bit         m_ovf = 1'b0;

  lcr_regif #(.N_LOC(NL), .CMD_DEPTH(CD), .RSP_DEPTH(RD)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic bit m_complete();
    longint n, len;
    n = cq.size();
    if (n == CD) return 1'b1;
    if (n < 6) return 1'b0;
    len = {cq[2], cq[3], cq[4], cq[5]};
    return n >= len;
  endfunction

  function automatic logic [31:0] m_status();
    int b;
    logic [31:0] s;
    b = 0;
    if (m_state == S_READY || m_state == S_RECV) b = CD - cq.size();
    else if (m_state == S_RESP) b = rq.size() - m_rd;
    s = 32'h80;
    s[23:8] = b[15:0];
    if (m_state == S_READY) s[6] = 1'b1;
    if (m_state == S_RESP && m_rd < rq.size()) s[4] = 1'b1;
    if ((m_state == S_READY || m_state == S_RECV) && !m_complete()) s[3] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] exp_read(input int addr);
    int w, off;
    w = addr >> 12;
    off = addr & 'hFFF;
    if (w >= NL) return '1;
    case (off)
      ACC: return (m_own == w) ? 32'hA0 : 32'h80;
      STS: return (m_own != w) ? '1 : m_status();
      DAT: begin
        if (m_own != w) return '1;
        if (m_state == S_RESP && m_rd < rq.size()) return {24'h0, rq[m_rd]};
        return 32'hFF;
      end
      IDR: return ID_WORD;
      REV: return REV_WORD;
      default: return '0;
    endcase
  endfunction

  function automatic void m_write(input int addr, input logic [31:0] d);
    int w, off;
    w = addr >> 12;
    off = addr & 'hFFF;
    if (w >= NL) return;
    if (off == ACC) begin
      if (d[5] && m_own == w) m_own = -1;
      else if (d[1] && m_own == -1) m_own = w;
    end else if (off == STS && m_own == w) begin
      if (d[6] && m_state != S_EXEC) begin
        m_state = S_READY; cq.delete(); rq.delete(); m_rd = 0; m_ovf = 1'b0;
      end else if (d[5] && m_state == S_RECV && m_complete()) m_state = S_EXEC;
      else if (d[1] && m_state == S_RESP) m_rd = 0;
    end else if (off == DAT && m_own == w) begin
      if (m_state == S_READY || (m_state == S_RECV && !m_complete())) begin
        cq.push_back(d[7:0]); m_state = S_RECV;
      end else if (m_state == S_RECV) m_ovf = 1'b1;
    end
  endfunction

  task automatic bus_wr(input int addr, input logic [31:0] d);
    bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = addr[14:0]; bus_wdata_i = d;
    @(posedge clk_i);
    m_write(addr, d);
    #1 bus_en_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(input int addr, input string req);
    bus_en_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = addr[14:0];
    #1 chk(bus_rdata_o, exp_read(addr), req);
    @(posedge clk_i);
    if ((addr & 'hFFF) == DAT && m_own == (addr >> 12) && m_state == S_RESP && m_rd < rq.size())
      m_rd++;
    #1 bus_en_i = 1'b0;
  endtask

  task automatic rsp_load(input logic [7:0] b);
    rsp_wr_i = 1'b1; rsp_byte_i = b;
    @(posedge clk_i);
    if (m_state == S_EXEC && rq.size() < RD) rq.push_back(b);
    #1 rsp_wr_i = 1'b0;
  endtask

  task automatic finish_exec();
    done_i = 1'b1;
    @(posedge clk_i);
    if (m_state == S_EXEC) begin m_state = S_RESP; m_rd = 0; end
    #1 done_i = 1'b0;
  endtask

  // per-clock comparison of the sideband outputs
  always @(negedge clk_i) begin
    if (run_cmp) begin
      chk({31'h0, exec_o}, {31'h0, m_state == S_EXEC}, "R8 exec_o");
      chk({31'h0, overflow_o}, {31'h0, m_ovf}, "R7 overflow_o");
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] cmd_a[10];
    cmd_a = '{8'h00, 8'hC1, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h01, 8'h02, 8'h03, 8'h04};
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    run_cmp = 1'b1;
    @(posedge clk_i); #1;

    // reset state and decode
    chk(exp_read(ACC), 32'h80, "R2 model reset");
    bus_rd(ACC, "R2 reset access");
    bus_rd(STS, "R3 unowned status");
    bus_rd((1 << 12) | DAT, "R3 unowned data");
    bus_rd(IDR, "R1 id");
    bus_rd((3 << 12) | REV, "R1 rev");
    bus_rd((6 << 12) | ACC, "R1 out of range");
    bus_rd('h008, "R1 unmapped offset");

    // ownership
    bus_wr(STS, 32'h40);                       // unowned, ignored
    bus_wr((2 << 12) | ACC, 32'h02);
    bus_rd((2 << 12) | ACC, "R2 claimed");
    bus_wr(ACC, 32'h02);                       // busy, ignored
    bus_rd(ACC, "R2 second claim refused");
    bus_rd((2 << 12) | STS, "R4 idle status");
    chk(bus_rdata_o, 32'h80, "R4 idle value");
    bus_wr(ACC, 32'h20);                       // not owner
    bus_rd((2 << 12) | ACC, "R2 foreign release ignored");
    bus_wr((2 << 12) | ACC, 32'h20);
    bus_rd((2 << 12) | ACC, "R2 released");
    bus_wr(ACC, 32'h02);
    bus_rd(ACC, "R2 claim window 0");

    // ready and command reception
    bus_wr(STS, 32'h40);
    bus_rd(STS, "R5 ready");
    bus_wr((1 << 12) | DAT, 32'h99);            // foreign window
    bus_rd(STS, "R3 foreign data write ignored");
    for (int i = 0; i < 10; i++) begin
      bus_wr(DAT, {24'h0, cmd_a[i]});
      bus_rd(STS, "R6 status per byte");
    end
    chk(m_status() & 32'h8, 32'h0, "R6 expect dropped");
    bus_wr(DAT, 32'hEE);
    bus_rd(STS, "R7 status after overflow");
    for (int i = 0; i < 10; i++) begin
      cmd_idx_i = 4'(i);
      #1 chk({24'h0, cmd_byte_o}, {24'h0, cq[i]}, "R8 command byte");
    end

    // execution
    bus_wr(STS, 32'h20);
    bus_rd(STS, "R8 executing status");
    bus_wr(STS, 32'h40);
    bus_wr(DAT, 32'h77);
    bus_rd(STS, "R12 ready ignored in exec");
    for (int i = 0; i < 10; i++) rsp_load(8'hA0 + 8'(i));
    finish_exec();
    bus_rd(STS, "R9 response status");

    // response drain, retry
    for (int i = 0; i < 3; i++) bus_rd(DAT, "R10 data read");
    bus_rd(STS, "R10 partial status");
    bus_wr(STS, 32'h02);
    bus_rd(STS, "R11 rewound status");
    for (int i = 0; i < RD; i++) bus_rd(DAT, "R11 data after rewind");
    bus_rd(DAT, "R10 read past end");
    bus_rd(STS, "R10 available cleared");

    // short header length, early go, empty response
    bus_wr(STS, 32'h40);
    bus_rd(STS, "R5 ready clears overflow");
    bus_wr(DAT, 32'h00); bus_wr(DAT, 32'hC1); bus_wr(DAT, 32'h00);
    bus_wr(STS, 32'h20);
    bus_rd(STS, "R8 early go ignored");
    bus_wr(DAT, 32'h00); bus_wr(DAT, 32'h00);
    bus_rd(STS, "R6 five bytes still expect");
    bus_wr(DAT, 32'h02);
    bus_rd(STS, "R6 short length completes at six");
    bus_wr(DAT, 32'h55);
    bus_rd(STS, "R7 overflow short cmd");
    bus_wr(STS, 32'h20);
    finish_exec();
    bus_rd(STS, "R9 empty response");
    bus_rd(DAT, "R10 empty read");

    // length larger than buffer
    bus_wr(STS, 32'h40);
    bus_wr(DAT, 32'h00); bus_wr(DAT, 32'hC1);
    bus_wr(DAT, 32'h00); bus_wr(DAT, 32'h00); bus_wr(DAT, 32'h01); bus_wr(DAT, 32'h00);
    for (int i = 6; i < CD - 1; i++) bus_wr(DAT, 32'(i));
    bus_rd(STS, "R6 one byte left");
    bus_wr(DAT, 32'h3C);
    bus_rd(STS, "R6 full buffer drops expect");
    bus_wr(DAT, 32'h3D);
    bus_rd(STS, "R7 overflow on full");
    bus_wr(STS, 32'h20);
    bus_rd(STS, "R8 exec after full");

    // release and re-claim from another window
    bus_wr(ACC, 32'h20);
    bus_rd(STS, "R3 released status");
    bus_rd(DAT, "R3 released data");
    bus_wr((4 << 12) | ACC, 32'h02);
    bus_rd((4 << 12) | STS, "R3 new owner status");
    bus_rd(ACC, "R2 old owner access");

    repeat (2) @(posedge clk_i);
    #1 run_cmp = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule